// File: doc/BRIEF.md
# Run-time Collapsible Register Pipeline

This block is a short chain of pipeline register stages. Each stage talks to its neighbours through a valid/ready handshake. Every packet carries a control vector next to its payload, with one 2-bit command field for each stage. The command tells a stage either to keep its current mode, to stop registering and become a wire, or to start registering again. The depth of the chain therefore changes while traffic is flowing, one packet at a time.

A stage in registered mode takes a packet only when it is empty. It holds the packet and shows it downstream, and it empties once the downstream side accepts the packet. A stage in transparent mode passes valid and data forward and ready backward without any register, so it merges with its neighbour into one logical stage. A mode change happens only at a packet boundary. Each stage counts the packets it captures, so the effect of collapsing the chain can be seen at the ports.

Top module: `flexpipe_chain`

## Requirements
- R1: After reset every stage is in registered mode and empty, every capture counter reads zero, `out_valid` is low, and `in_ready` is high while the packet at the input carries keep commands.
- R2: A registered stage takes a packet only when it is empty and shows it downstream from the next cycle. Its upstream ready is low while it holds a packet, and it empties in the cycle the downstream side accepts the packet.
- R3: The command for stage i is `in_ctl[2i+1:2i]`, with stage 0 nearest the input. The codes are 00 keep, 01 collapse, 10 expand, and 11 reserved. Code 11 acts exactly like keep.
- R4: When an empty registered stage sees a valid packet with command 01, the packet passes straight through in the same cycle and is not captured. The stage becomes transparent when the packet is accepted downstream.
- R5: A transparent stage forwards valid, data and control combinationally, takes its upstream ready directly from its downstream ready, and captures nothing.
- R6: A transparent stage that sees a valid packet with command 10 raises its upstream ready, even when its downstream ready is low. It captures the packet and becomes registered again.
- R7: A collapse command that reaches a registered stage while the stage is occupied waits. The stage holds its ready low until it drains, and only then does the collapse apply.
- R8: Each stage has a CW-bit wrapping counter that grows by exactly one for every packet the stage captures into its register.
- R9: Packets leave in the order they entered, with payload and control vector unchanged, under every mix of modes.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable in the next cycle, provided the input side keeps its offered packet stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream packet valid |
| in_ready | output | 1 | Chain accepts the upstream packet |
| in_data | input | W | Upstream payload |
| in_ctl | input | 2*NSTAGE | Per-stage command fields of the packet |
| out_valid | output | 1 | Downstream packet valid |
| out_ready | input | 1 | Downstream sink accepts |
| out_data | output | W | Downstream payload |
| out_ctl | output | 2*NSTAGE | Command fields travelling with the packet |
| cap_count | output | NSTAGE*CW | Capture counters, stage i in bits [i*CW +: CW] |

## Verification
The bench goes after a collapse command that arrives at a full stage. A design that switched mode at once would drop or reorder the packet held inside, and the scoreboard and the ready check would both catch it. It also sends an expand command while the sink is stalled. A design that tied ready to the downstream side in that case would never reinstate the stage and would keep `in_ready` low. A fully transparent chain is checked for same-cycle pass-through and for ready following the sink, so a design that stored packets in transparent mode would show extra latency and spurious capture counts. Reserved code 11 and random mixes of commands under random backpressure are compared cycle by cycle with a behavioural model.

// File: rtl/flexpipe_pkg.sv
package flexpipe_pkg;

  typedef enum logic [1:0] {
    TAG_KEEP     = 2'b00,
    TAG_COLLAPSE = 2'b01,
    TAG_EXPAND   = 2'b10,
    TAG_RSVD     = 2'b11
  } pipe_tag_e;

  typedef enum logic {
    MODE_REG  = 1'b0,
    MODE_THRU = 1'b1
  } stage_mode_e;

  // Reserved code behaves as keep.
  function automatic pipe_tag_e decode_tag(input logic [1:0] raw);
    pipe_tag_e t;
    t = pipe_tag_e'(raw);
    if (t == TAG_RSVD) t = TAG_KEEP;
    return t;
  endfunction

endpackage

// File: rtl/flexpipe_capcnt.sv
module flexpipe_capcnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  output logic [CW-1:0] count
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/flexpipe_stage.sv
module flexpipe_stage
  import flexpipe_pkg::*;
#(
  parameter int W    = 8,
  parameter int CTLW = 6,
  parameter int IDX  = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            up_valid,
  output logic            up_ready,
  input  logic [W-1:0]    up_data,
  input  logic [CTLW-1:0] up_ctl,
  output logic            dn_valid,
  input  logic            dn_ready,
  output logic [W-1:0]    dn_data,
  output logic [CTLW-1:0] dn_ctl,
  output logic            capture
);

  localparam int FLD_LSB = 2 * IDX;

  stage_mode_e     mode_q, mode_d;
  logic            full_q, full_d;
  logic [W-1:0]    data_q;
  logic [CTLW-1:0] ctl_q;
  pipe_tag_e       my_tag;
  logic            want_collapse;
  logic            want_expand;
  logic            load;

  always_comb begin
    my_tag        = decode_tag(up_ctl[FLD_LSB +: 2]);
    want_collapse = up_valid && (my_tag == TAG_COLLAPSE);
    want_expand   = up_valid && (my_tag == TAG_EXPAND);
  end

  // Next-state and handshake logic
  always_comb begin
    mode_d   = mode_q;
    full_d   = full_q;
    load     = 1'b0;
    up_ready = 1'b0;
    dn_valid = 1'b0;
    dn_data  = data_q;
    dn_ctl   = ctl_q;
    unique case (mode_q)
      MODE_REG: begin
        if (full_q) begin
          dn_valid = 1'b1;
          if (dn_ready) full_d = 1'b0;
        end else if (want_collapse) begin
          dn_valid = 1'b1;
          dn_data  = up_data;
          dn_ctl   = up_ctl;
          up_ready = dn_ready;
          if (dn_ready) mode_d = MODE_THRU;
        end else begin
          up_ready = 1'b1;
          if (up_valid) begin
            load   = 1'b1;
            full_d = 1'b1;
          end
        end
      end
      MODE_THRU: begin
        if (want_expand) begin
          up_ready = 1'b1;
          load     = 1'b1;
          full_d   = 1'b1;
          mode_d   = MODE_REG;
        end else begin
          dn_valid = up_valid;
          dn_data  = up_data;
          dn_ctl   = up_ctl;
          up_ready = dn_ready;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_REG;
      full_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      full_q <= full_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      data_q <= up_data;
      ctl_q  <= up_ctl;
    end
  end

  assign capture = load;

endmodule

// File: rtl/flexpipe_chain.sv
module flexpipe_chain #(
  parameter int W      = 8,
  parameter int NSTAGE = 3,
  parameter int CW     = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [W-1:0]           in_data,
  input  logic [2*NSTAGE-1:0]    in_ctl,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [W-1:0]           out_data,
  output logic [2*NSTAGE-1:0]    out_ctl,
  output logic [NSTAGE*CW-1:0]   cap_count
);

  localparam int CTLW = 2 * NSTAGE;

  logic            lnk_v [NSTAGE+1];
  logic            lnk_r [NSTAGE+1];
  logic [W-1:0]    lnk_d [NSTAGE+1];
  logic [CTLW-1:0] lnk_c [NSTAGE+1];

  assign lnk_v[0]      = in_valid;
  assign lnk_d[0]      = in_data;
  assign lnk_c[0]      = in_ctl;
  assign in_ready      = lnk_r[0];
  assign out_valid     = lnk_v[NSTAGE];
  assign out_data      = lnk_d[NSTAGE];
  assign out_ctl       = lnk_c[NSTAGE];
  assign lnk_r[NSTAGE] = out_ready;

  for (genvar gi = 0; gi < NSTAGE; gi++) begin : g_stage
    logic cap;

    flexpipe_stage #(
      .W    (W),
      .CTLW (CTLW),
      .IDX  (gi)
    ) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .up_valid (lnk_v[gi]),
      .up_ready (lnk_r[gi]),
      .up_data  (lnk_d[gi]),
      .up_ctl   (lnk_c[gi]),
      .dn_valid (lnk_v[gi+1]),
      .dn_ready (lnk_r[gi+1]),
      .dn_data  (lnk_d[gi+1]),
      .dn_ctl   (lnk_c[gi+1]),
      .capture  (cap)
    );

    flexpipe_capcnt #(
      .CW (CW)
    ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cap),
      .count (cap_count[gi*CW +: CW])
    );
  end

endmodule

// File: rtl/flexpipe_chain_chk.sv
module flexpipe_chain_chk #(
  parameter int W      = 8,
  parameter int NSTAGE = 3,
  parameter int CW     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [W-1:0]         in_data,
  input logic [2*NSTAGE-1:0]  in_ctl,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [W-1:0]         out_data,
  input logic [2*NSTAGE-1:0]  out_ctl,
  input logic [NSTAGE*CW-1:0] cap_count
);

  int  held;
  logic in_hs, out_hs;

  assign in_hs  = in_valid && in_ready;
  assign out_hs = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 0;
    else        held <= held + int'(in_hs) - int'(out_hs);
  end

  // R9
  no_phantom_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_hs |-> (held + int'(in_hs)) > 0);

  // R2
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held <= NSTAGE);

  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_ctl)));

  // R8
  first_cap_needs_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_count[CW-1:0]) |-> $past(in_hs));

  for (genvar gi = 0; gi < NSTAGE; gi++) begin : g_cnt
    // R8
    cap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_count[gi*CW +: CW]) |->
        (cap_count[gi*CW +: CW] == CW'($past(cap_count[gi*CW +: CW]) + CW'(1))));
  end

endmodule

bind flexpipe_chain flexpipe_chain_chk #(.W(W), .NSTAGE(NSTAGE), .CW(CW)) u_chk (.*);

// File: tb/sim_flexpipe_chain.sv
module sim_flexpipe_chain;

  localparam int W       = 8;
  localparam int NS      = 3;
  localparam int CW      = 8;
  localparam int CTLW    = 2 * NS;
  localparam int TCLK    = 10;
  localparam int TIMEOUT = 100000;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic            in_ready;
  logic [W-1:0]    in_data;
  logic [CTLW-1:0] in_ctl;
  logic            out_valid;
  logic            out_ready;
  logic [W-1:0]    out_data;
  logic [CTLW-1:0] out_ctl;
  logic [NS*CW-1:0] cap_count;

  int checks = 0;
  int fails  = 0;
  int rdy_mode = 0;   // 0 always ready, 1 stalled, 2 random

  flexpipe_chain #(.W(W), .NSTAGE(NS), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_ctl(in_ctl),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_ctl(out_ctl),
    .cap_count(cap_count)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit              m_full [NS];
  bit              m_thru [NS];
  logic [W-1:0]    m_dat  [NS];
  logic [CTLW-1:0] m_ctl  [NS];
  int              m_cnt  [NS];
  bit              e_v [NS+1];
  bit              e_r [NS+1];
  logic [W-1:0]    e_d [NS+1];
  logic [CTLW-1:0] e_c [NS+1];
  logic [W+CTLW-1:0] sb [$];
  logic [W-1:0]    s_out_d;
  logic [CTLW-1:0] s_out_c;

  function automatic int cmd_of(input logic [CTLW-1:0] c, input int i);
    int t;
    t = int'(c[2*i +: 2]);
    return (t == 3) ? 0 : t;   // 11 acts as keep
  endfunction

  task automatic model_eval();
    e_v[0] = in_valid; e_d[0] = in_data; e_c[0] = in_ctl;
    for (int i = 0; i < NS; i++) begin
      int t;
      t = cmd_of(e_c[i], i);
      e_v[i+1] = 1'b0; e_d[i+1] = e_d[i]; e_c[i+1] = e_c[i];
      if (!m_thru[i]) begin
        if (m_full[i]) begin
          e_v[i+1] = 1'b1; e_d[i+1] = m_dat[i]; e_c[i+1] = m_ctl[i];
        end else if (e_v[i] && t == 1) begin
          e_v[i+1] = 1'b1;
        end
      end else if (!(e_v[i] && t == 2)) begin
        e_v[i+1] = e_v[i];
      end
    end
    e_r[NS] = out_ready;
    for (int i = NS - 1; i >= 0; i--) begin
      int t;
      t = cmd_of(e_c[i], i);
      if (!m_thru[i]) e_r[i] = m_full[i] ? 1'b0 : ((e_v[i] && t == 1) ? e_r[i+1] : 1'b1);
      else            e_r[i] = (e_v[i] && t == 2) ? 1'b1 : e_r[i+1];
    end
  endtask

  task automatic model_step();
    if (e_v[0] && e_r[0]) sb.push_back({e_d[0], e_c[0]});
    if (e_v[NS] && e_r[NS]) begin
      logic [W+CTLW-1:0] exp;
      if (sb.size() == 0) begin
        check(1'b0, "R9 unexpected output", longint'(s_out_d), 0);
      end else begin
        exp = sb.pop_front();
        check({s_out_d, s_out_c} == exp, "R9 order/content", longint'({s_out_d, s_out_c}), longint'(exp));
      end
    end
    for (int i = 0; i < NS; i++) begin
      int t;
      t = cmd_of(e_c[i], i);
      if (!m_thru[i]) begin
        if (m_full[i]) begin
          if (e_r[i+1]) m_full[i] = 1'b0;
        end else if (e_v[i] && t == 1) begin
          if (e_r[i+1]) m_thru[i] = 1'b1;
        end else if (e_v[i]) begin
          m_full[i] = 1'b1; m_dat[i] = e_d[i]; m_ctl[i] = e_c[i]; m_cnt[i]++;
        end
      end else if (e_v[i] && t == 2) begin
        m_thru[i] = 1'b0; m_full[i] = 1'b1; m_dat[i] = e_d[i]; m_ctl[i] = e_c[i]; m_cnt[i]++;
      end
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NS; i++) begin
      m_full[i] = 1'b0; m_thru[i] = 1'b0; m_cnt[i] = 0;
    end
    sb.delete();
  endtask

  initial model_reset();

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      model_eval();
      s_out_d = out_data; s_out_c = out_ctl;
      check(in_ready === e_r[0], "R2/R5/R6/R7 in_ready", longint'(in_ready), longint'(e_r[0]));
      check(out_valid === e_v[NS], "R2/R4/R5 out_valid", longint'(out_valid), longint'(e_v[NS]));
      if (e_v[NS])
        check(out_data === e_d[NS] && out_ctl === e_c[NS], "R5/R9 out payload",
              longint'({out_data, out_ctl}), longint'({e_d[NS], e_c[NS]}));
      for (int i = 0; i < NS; i++)
        check(cap_count[i*CW +: CW] === CW'(m_cnt[i]), "R8 capture count",
              longint'(cap_count[i*CW +: CW]), longint'(CW'(m_cnt[i])));
    end
  end

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else        model_step();
  end

  // ---------------- stimulus ----------------
  task automatic upd_ready();
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = 1'b0;
      default: out_ready = ($urandom % 3) != 0;
    endcase
  endtask

  // called and returning just after a falling edge
  task automatic xfer(input logic [W-1:0] d, input logic [CTLW-1:0] c);
    bit acc;
    in_valid = 1'b1; in_data = d; in_ctl = c;
    upd_ready();
    do begin
      #1; acc = in_ready;
      @(negedge clk);
      upd_ready();
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) begin
      upd_ready();
      @(negedge clk);
    end
    upd_ready();
  endtask

  function automatic logic [CTLW-1:0] rnd_ctl();
    logic [CTLW-1:0] c;
    for (int i = 0; i < NS; i++) begin
      int r;
      r = $urandom % 8;
      c[2*i +: 2] = (r == 0) ? 2'b01 : (r == 1) ? 2'b10 : (r == 2) ? 2'b11 : 2'b00;
    end
    return c;
  endfunction

  initial begin
    logic [CW-1:0] snap;
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; in_ctl = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid after reset", longint'(out_valid), 0);
    check(cap_count == '0, "R1 counters after reset", longint'(cap_count), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", longint'(in_ready), 1);

    // R2 plain registered traffic
    rdy_mode = 0;
    for (int k = 0; k < 8; k++) xfer(W'(8'h10 + k), '0);
    idle(6);

    // R7 collapse command at a full stage 0
    rdy_mode = 1;
    xfer(8'hA1, '0); xfer(8'hA2, '0); xfer(8'hA3, '0);
    snap = cap_count[0 +: CW];
    in_valid = 1'b1; in_data = 8'hA4; in_ctl = 6'b000001;
    #1;
    check(in_ready == 1'b0, "R7 ready low while stage occupied", longint'(in_ready), 0);
    @(negedge clk); #1;
    check(in_ready == 1'b0, "R7 ready still low", longint'(in_ready), 0);
    @(negedge clk);
    rdy_mode = 0;
    xfer(8'hA4, 6'b000001);
    idle(6);
    check(cap_count[0 +: CW] == snap, "R4 collapsed packet not captured",
          longint'(cap_count[0 +: CW]), longint'(snap));

    // R4 collapse the remaining two stages, keep on stage 0
    xfer(8'hB0, 6'b010100);
    idle(4);
    // R5 fully transparent chain
    in_valid = 1'b1; in_data = 8'h5C; in_ctl = '0; out_ready = 1'b1;
    #1;
    check(out_valid == 1'b1 && out_data == 8'h5C, "R5 same-cycle pass-through",
          longint'({out_valid, out_data}), longint'({1'b1, 8'h5C}));
    out_ready = 1'b0;
    #1;
    check(in_ready == 1'b0, "R5 ready follows sink", longint'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    idle(2);

    // R6 expand stage 1 while the sink is stalled
    rdy_mode = 1;
    snap = cap_count[CW +: CW];
    in_valid = 1'b1; in_data = 8'hE1; in_ctl = 6'b001000; out_ready = 1'b0;
    #1;
    check(in_ready == 1'b1, "R6 expand accepted under stall", longint'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(cap_count[CW +: CW] == CW'(snap + 1), "R6 stage 1 captured",
          longint'(cap_count[CW +: CW]), longint'(CW'(snap + 1)));
    rdy_mode = 0;
    idle(4);

    // R3 reserved code acts as keep on registered stage 1
    snap = cap_count[CW +: CW];
    xfer(8'h33, 6'b001100);
    idle(5);
    check(cap_count[CW +: CW] == CW'(snap + 1), "R3 reserved code captured like keep",
          longint'(cap_count[CW +: CW]), longint'(CW'(snap + 1)));

    // random mix of commands and backpressure
    rdy_mode = 2;
    for (int k = 0; k < 800; k++) begin
      xfer(W'($urandom), rnd_ctl());
      if (($urandom % 5) == 0) idle(1 + ($urandom % 3));
    end
    rdy_mode = 0;
    idle(10);
    check(sb.size() == 0, "R9 all packets delivered", longint'(sb.size()), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (TIMEOUT) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", TIMEOUT);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule